// File: doc/BRIEF.md
# CAN Interrupt Gathering and Register Write Guard

This block is the register front end of a CAN controller. It collects status events from the transmit mailboxes, the two receive FIFOs, the error logic, the sleep logic and the receive line. It merges them into four interrupt lines: transmit, receive FIFO 0, receive FIFO 1, and error/status change. Every event has its own enable bit. Events that arrive as one-cycle pulses are held in sticky flags until software clears them by writing 1.

The same block watches every write on the 32-bit register bus. It decides whether a write to a configuration register, a transmit mailbox or a filter bank may take effect, given the controller's current state. For registers that live outside this slice, it raises a one-cycle write-accept strobe during the bus write. The downstream storage commits the write data only when that strobe is high. A blocked write produces no strobe and raises no error.

Top module: `can_irq_guard`

## Requirements
- R1: After reset, the master control word at 0x000 reads 0x0001_0002 and the enable word at 0x014 reads 0. The transmit flags at 0x004 and the status word at 0x010 read 0. The filter control word at 0x01C reads 1 (bit 0 is the filter-init bit). All four interrupt lines are low.
- R2: An access counts only when all four byte enables are 1 and address bits [1:0] are 0. Any other write changes no register and raises no strobe. Any other read returns 0.
- R3: A pulse on tx_done_i[m] sets the sticky flag at bit m of 0x004. The flag is cleared by writing 1 to that bit. irq_tx_o is high while any flag is set whose enable bit m in 0x014 is 1.
- R4: Word 0x008 (FIFO 0) and word 0x00C (FIFO 1) read as follows: bits [1:0] give the live pending count, bit 2 a sticky full flag and bit 3 a sticky overrun flag. Both flags are cleared by writing 1. Each FIFO drives its own line. Enable bits NMBX, NMBX+1 and NMBX+2 of 0x014 gate pending-nonzero, full and overrun for FIFO 0. The next three bits gate the same events for FIFO 1.
- R5: Word 0x010 reads as follows: bit 0 is the live error level, and bit 1 is a sticky wakeup flag, set by sof_i while sleep_i is 1. Bit 2 is a sticky sleep-entry flag, set when sleep_i goes from 0 to 1. irq_es_o is gated by enable bits NMBX+6, NMBX+7 and NMBX+8 for error, wakeup and sleep entry.
- R6: When a flag's set event and a write-1 clear of the same flag arrive in one cycle, the flag ends up set.
- R7: A write to the bit-timing word at 0x018 raises cfg_wacc_o[0] only while init_mode_i is 1.
- R8: Mailbox m occupies the four words from 0x040+16*m. A write there raises mbx_wacc_o[m] only while mbx_empty_i[m] is 1. An address beyond the last mailbox raises nothing.
- R9: Writes to the filter mode word (0x020), the filter scale word (0x024) and the FIFO-assignment word (0x028) raise cfg_wacc_o[1], [2] and [3]. Each strobe is raised only while the filter-init bit is 1.
- R10: Filter bank b occupies the two words from 0x100+8*b. A write there raises fbank_wacc_o[b] only while the filter-init bit is 1 or bit b of the activation word at 0x02C is 0.
- R11: An event whose enable bit is 0 keeps its line low, even while its flag or level is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| init_mode_i | input | 1 | Controller is in initialization mode |
| mbx_empty_i | input | NMBX | Per-mailbox empty state |
| tx_done_i | input | NMBX | Per-mailbox request-complete pulse |
| rx0_cnt_i | input | 2 | FIFO 0 pending-message count |
| rx0_full_i | input | 1 | FIFO 0 full pulse |
| rx0_ovr_i | input | 1 | FIFO 0 overrun pulse |
| rx1_cnt_i | input | 2 | FIFO 1 pending-message count |
| rx1_full_i | input | 1 | FIFO 1 full pulse |
| rx1_ovr_i | input | 1 | FIFO 1 overrun pulse |
| err_i | input | 1 | Error condition level |
| sleep_i | input | 1 | Controller is asleep |
| sof_i | input | 1 | Start of frame seen on the receive line |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx0_o | output | 1 | FIFO 0 interrupt |
| irq_rx1_o | output | 1 | FIFO 1 interrupt |
| irq_es_o | output | 1 | Error/status-change interrupt |
| cfg_wacc_o | output | 4 | Write accept: bit timing, filter mode, filter scale, FIFO assignment |
| mbx_wacc_o | output | NMBX | Per-mailbox write accept |
| fbank_wacc_o | output | NBANK | Per-filter-bank write accept |

## Verification
The block's results fall due at different times after a stimulus:

- **Write-accept strobes and read data** are combinational, so they are due in the same cycle as the access. The bench drives the access just after a falling edge, samples one nanosecond later, and removes the write strobe before the next rising edge.
- **Sticky flags** and the interrupts that follow from them are due one rising edge after the pulse or write. The bench holds each pulse across exactly one rising edge and checks at the next falling edge.
- **Pending counts and the error level** reach their lines combinationally. They are checked within the cycle in which they are driven.

// File: rtl/canig_pkg.sv
package canig_pkg;

  localparam int BUS_AW = 12;

  localparam logic [BUS_AW-1:0] A_CTRL  = 12'h000;
  localparam logic [BUS_AW-1:0] A_TXF   = 12'h004;
  localparam logic [BUS_AW-1:0] A_RX0   = 12'h008;
  localparam logic [BUS_AW-1:0] A_RX1   = 12'h00C;
  localparam logic [BUS_AW-1:0] A_EST   = 12'h010;
  localparam logic [BUS_AW-1:0] A_IEN   = 12'h014;
  localparam logic [BUS_AW-1:0] A_BTIME = 12'h018;
  localparam logic [BUS_AW-1:0] A_FCTL  = 12'h01C;
  localparam logic [BUS_AW-1:0] A_FMODE = 12'h020;
  localparam logic [BUS_AW-1:0] A_FSCL  = 12'h024;
  localparam logic [BUS_AW-1:0] A_FASN  = 12'h028;
  localparam logic [BUS_AW-1:0] A_FACT  = 12'h02C;

  localparam int MBX_BASE    = 'h040;
  localparam int MBX_STRIDE  = 16;
  localparam int BANK_BASE   = 'h100;
  localparam int BANK_STRIDE = 8;

  localparam logic [31:0] CTRL_RST = 32'h0001_0002;

  // registers held inside this slice, one write enable each
  localparam int L_CTRL = 0;
  localparam int L_TXF  = 1;
  localparam int L_RX0  = 2;
  localparam int L_RX1  = 3;
  localparam int L_EST  = 4;
  localparam int L_IEN  = 5;
  localparam int L_FCTL = 6;
  localparam int L_FACT = 7;
  localparam int LOC_N  = 8;
  localparam logic [BUS_AW-1:0] LOC_ADDR [LOC_N] =
    '{A_CTRL, A_TXF, A_RX0, A_RX1, A_EST, A_IEN, A_FCTL, A_FACT};

  // guarded configuration words held downstream
  localparam int CFG_N = 4;
  localparam logic [BUS_AW-1:0] CFG_ADDR [CFG_N] = '{A_BTIME, A_FMODE, A_FSCL, A_FASN};

  // a word access needs every byte lane and an aligned address
  function automatic logic word_ok(input logic [3:0] be, input logic [1:0] lo);
    return (be == 4'hF) && (lo == 2'b00);
  endfunction

  function automatic logic in_window(input logic [BUS_AW-1:0] a, input int base, input int span);
    int ai;
    ai = int'(a);
    return (ai >= base) && (ai < base + span);
  endfunction

  function automatic logic masked_or(input logic [15:0] ev, input logic [15:0] en);
    return |(ev & en);
  endfunction

endpackage

// File: rtl/canig_sticky.sv
module canig_sticky #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q;

  // a set arriving in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= (q_q & ~clr_i) | set_i;
  end

  assign q_o = q_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & ~$past(q_o) & ~$past(set_i)) == '0));

  // R3
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~q_o & $past(q_o) & ~$past(clr_i)) == '0));

endmodule

// File: rtl/canig_guard.sv
module canig_guard
  import canig_pkg::*;
#(
  parameter int NMBX  = 3,
  parameter int NBANK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic              wr_i,
  input  logic              init_mode_i,
  input  logic              finit_i,
  input  logic [NBANK-1:0]  fact_i,
  input  logic [NMBX-1:0]   mbx_empty_i,
  output logic [LOC_N-1:0]  loc_we_o,
  output logic [CFG_N-1:0]  cfg_wacc_o,
  output logic [NMBX-1:0]   mbx_wacc_o,
  output logic [NBANK-1:0]  fbank_wacc_o
);

  localparam int STRB_N = LOC_N + CFG_N + NMBX + NBANK;

  logic              acc_ok;
  logic [CFG_N-1:0]  cfg_hit;
  logic [CFG_N-1:0]  cfg_cond;
  logic [NMBX-1:0]   mbx_hit;
  logic [NBANK-1:0]  bank_hit;
  logic [NBANK-1:0]  bank_open;
  logic [STRB_N-1:0] all_strb;

  assign acc_ok = wr_i && word_ok(be_i, addr_i[1:0]);

  for (genvar l = 0; l < LOC_N; l++) begin : g_loc
    assign loc_we_o[l] = acc_ok && (addr_i == LOC_ADDR[l]);
  end

  // bit timing follows init mode; the three filter layout words follow filter init
  assign cfg_cond = {finit_i, finit_i, finit_i, init_mode_i};
  for (genvar c = 0; c < CFG_N; c++) begin : g_cfg
    assign cfg_hit[c]    = addr_i == CFG_ADDR[c];
    assign cfg_wacc_o[c] = acc_ok && cfg_hit[c] && cfg_cond[c];
  end

  for (genvar m = 0; m < NMBX; m++) begin : g_mbx
    assign mbx_hit[m]    = in_window(addr_i, MBX_BASE + m * MBX_STRIDE, MBX_STRIDE);
    assign mbx_wacc_o[m] = acc_ok && mbx_hit[m] && mbx_empty_i[m];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_hit[b]     = in_window(addr_i, BANK_BASE + b * BANK_STRIDE, BANK_STRIDE);
    assign bank_open[b]    = finit_i || !fact_i[b];
    assign fbank_wacc_o[b] = acc_ok && bank_hit[b] && bank_open[b];
  end

  assign all_strb = {loc_we_o, cfg_wacc_o, mbx_wacc_o, fbank_wacc_o};

  // R2
  whole_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|all_strb) |-> (be_i == 4'hF && addr_i[1:0] == 2'b00 && wr_i));

  // R2
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_strb));

  // R7
  btime_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wacc_o[0] |-> init_mode_i);

  // R8
  mbx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_wacc_o & ~mbx_empty_i) == '0);

  // R9
  flayout_finit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_wacc_o[CFG_N-1:1]) |-> finit_i);

  // R10
  bank_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fbank_wacc_o & fact_i & {NBANK{!finit_i}}) == '0);

endmodule

// File: rtl/canig_irq.sv
module canig_irq
  import canig_pkg::*;
#(
  parameter int NMBX = 3,
  localparam int IEN_W = NMBX + 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IEN_W-1:0] ien_i,
  input  logic [NMBX-1:0]  txf_i,
  input  logic [1:0]       rx0_cnt_i,
  input  logic [1:0]       rx0_flg_i,
  input  logic [1:0]       rx1_cnt_i,
  input  logic [1:0]       rx1_flg_i,
  input  logic             err_i,
  input  logic [1:0]       es_flg_i,
  output logic             irq_tx_o,
  output logic             irq_rx0_o,
  output logic             irq_rx1_o,
  output logic             irq_es_o
);

  logic [NMBX-1:0] tx_en;
  logic [2:0]      rx0_en, rx1_en, es_en;
  logic [2:0]      rx0_ev, rx1_ev, es_ev;

  assign tx_en  = ien_i[NMBX-1:0];
  assign rx0_en = ien_i[NMBX+2:NMBX];
  assign rx1_en = ien_i[NMBX+5:NMBX+3];
  assign es_en  = ien_i[NMBX+8:NMBX+6];

  // event order inside each group: {overrun, full, pending} / {sleep, wake, error}
  assign rx0_ev = {rx0_flg_i, rx0_cnt_i != 2'b00};
  assign rx1_ev = {rx1_flg_i, rx1_cnt_i != 2'b00};
  assign es_ev  = {es_flg_i, err_i};

  assign irq_tx_o  = masked_or(16'(txf_i), 16'(tx_en));
  assign irq_rx0_o = masked_or(16'(rx0_ev), 16'(rx0_en));
  assign irq_rx1_o = masked_or(16'(rx1_ev), 16'(rx1_en));
  assign irq_es_o  = masked_or(16'(es_ev), 16'(es_en));

  // R11
  tx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en == '0) |-> !irq_tx_o);

  // R11
  es_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (es_en == 3'b000) |-> !irq_es_o);

  // R4
  rx0_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx0_cnt_i != 2'b00 && rx0_en[0]) |-> irq_rx0_o);

  // R4
  rx1_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx1_cnt_i != 2'b00 && rx1_en[0]) |-> irq_rx1_o);

endmodule

// File: rtl/can_irq_guard.sv
module can_irq_guard
  import canig_pkg::*;
#(
  parameter int NMBX  = 3,
  parameter int NBANK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  output logic [31:0]       bus_rdata,
  input  logic              init_mode_i,
  input  logic [NMBX-1:0]   mbx_empty_i,
  input  logic [NMBX-1:0]   tx_done_i,
  input  logic [1:0]        rx0_cnt_i,
  input  logic              rx0_full_i,
  input  logic              rx0_ovr_i,
  input  logic [1:0]        rx1_cnt_i,
  input  logic              rx1_full_i,
  input  logic              rx1_ovr_i,
  input  logic              err_i,
  input  logic              sleep_i,
  input  logic              sof_i,
  output logic              irq_tx_o,
  output logic              irq_rx0_o,
  output logic              irq_rx1_o,
  output logic              irq_es_o,
  output logic [CFG_N-1:0]  cfg_wacc_o,
  output logic [NMBX-1:0]   mbx_wacc_o,
  output logic [NBANK-1:0]  fbank_wacc_o
);

  localparam int IEN_W = NMBX + 9;

  initial begin
    if (NMBX < 1 || NMBX > 7 || NBANK < 1 || BANK_BASE + NBANK * BANK_STRIDE > 4096)
      $error("can_irq_guard: NMBX or NBANK out of range");
  end

  logic [LOC_N-1:0] loc_we;
  logic [31:0]      ctrl_q;
  logic [IEN_W-1:0] ien_q;
  logic             finit_q;
  logic [NBANK-1:0] fact_q;
  logic             sleep_q;

  logic             sleep_entry;
  logic             wake_ev;
  logic [NMBX-1:0]  txf;
  logic [1:0]       rx0_flg, rx1_flg, es_flg;
  logic [NMBX-1:0]  tx_clr;
  logic [1:0]       rx0_clr, rx1_clr, es_clr;

  canig_guard #(.NMBX(NMBX), .NBANK(NBANK)) u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (bus_addr),
    .be_i         (bus_be),
    .wr_i         (bus_wr),
    .init_mode_i  (init_mode_i),
    .finit_i      (finit_q),
    .fact_i       (fact_q),
    .mbx_empty_i  (mbx_empty_i),
    .loc_we_o     (loc_we),
    .cfg_wacc_o   (cfg_wacc_o),
    .mbx_wacc_o   (mbx_wacc_o),
    .fbank_wacc_o (fbank_wacc_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      ien_q   <= '0;
      finit_q <= 1'b1;
      fact_q  <= '0;
      sleep_q <= 1'b1;
    end else begin
      if (loc_we[L_CTRL]) ctrl_q  <= bus_wdata;
      if (loc_we[L_IEN])  ien_q   <= bus_wdata[IEN_W-1:0];
      if (loc_we[L_FCTL]) finit_q <= bus_wdata[0];
      if (loc_we[L_FACT]) fact_q  <= bus_wdata[NBANK-1:0];
      sleep_q <= sleep_i;
    end
  end

  // write-one-to-clear masks
  assign tx_clr  = loc_we[L_TXF] ? bus_wdata[NMBX-1:0] : '0;
  assign rx0_clr = loc_we[L_RX0] ? bus_wdata[3:2] : 2'b00;
  assign rx1_clr = loc_we[L_RX1] ? bus_wdata[3:2] : 2'b00;
  assign es_clr  = loc_we[L_EST] ? bus_wdata[2:1] : 2'b00;

  assign sleep_entry = sleep_i && !sleep_q;
  assign wake_ev     = sof_i && sleep_i;

  canig_sticky #(.W(NMBX)) u_txf (
    .clk(clk), .rst_n(rst_n), .set_i(tx_done_i), .clr_i(tx_clr), .q_o(txf));

  canig_sticky #(.W(2)) u_rx0f (
    .clk(clk), .rst_n(rst_n), .set_i({rx0_ovr_i, rx0_full_i}), .clr_i(rx0_clr), .q_o(rx0_flg));

  canig_sticky #(.W(2)) u_rx1f (
    .clk(clk), .rst_n(rst_n), .set_i({rx1_ovr_i, rx1_full_i}), .clr_i(rx1_clr), .q_o(rx1_flg));

  canig_sticky #(.W(2)) u_esf (
    .clk(clk), .rst_n(rst_n), .set_i({sleep_entry, wake_ev}), .clr_i(es_clr), .q_o(es_flg));

  canig_irq #(.NMBX(NMBX)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ien_i     (ien_q),
    .txf_i     (txf),
    .rx0_cnt_i (rx0_cnt_i),
    .rx0_flg_i (rx0_flg),
    .rx1_cnt_i (rx1_cnt_i),
    .rx1_flg_i (rx1_flg),
    .err_i     (err_i),
    .es_flg_i  (es_flg),
    .irq_tx_o  (irq_tx_o),
    .irq_rx0_o (irq_rx0_o),
    .irq_rx1_o (irq_rx1_o),
    .irq_es_o  (irq_es_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (word_ok(bus_be, bus_addr[1:0])) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = ctrl_q;
        A_TXF:   bus_rdata = 32'(txf);
        A_RX0:   bus_rdata = {28'd0, rx0_flg, rx0_cnt_i};
        A_RX1:   bus_rdata = {28'd0, rx1_flg, rx1_cnt_i};
        A_EST:   bus_rdata = {29'd0, es_flg, err_i};
        A_IEN:   bus_rdata = 32'(ien_q);
        A_FCTL:  bus_rdata = {31'd0, finit_q};
        A_FACT:  bus_rdata = 32'(fact_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R5
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_entry |=> es_flg[1]);

  // R5
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && sleep_i) |=> es_flg[0]);

  // R5
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !es_flg[0]) |=> !es_flg[0]);

  // R2
  partial_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_be != 4'hF) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_can_irq_guard.sv
module sim_can_irq_guard;

  localparam int NMBX  = 3;
  localparam int NBANK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_rdata;
  logic        init_mode_i = 1'b0;
  logic [NMBX-1:0] mbx_empty_i = '0;
  logic [NMBX-1:0] tx_done_i = '0;
  logic [1:0]  rx0_cnt_i = '0, rx1_cnt_i = '0;
  logic        rx0_full_i = 0, rx0_ovr_i = 0, rx1_full_i = 0, rx1_ovr_i = 0;
  logic        err_i = 0, sleep_i = 1'b1, sof_i = 0;
  logic        irq_tx_o, irq_rx0_o, irq_rx1_o, irq_es_o;
  logic [3:0]  cfg_wacc_o;
  logic [NMBX-1:0]  mbx_wacc_o;
  logic [NBANK-1:0] fbank_wacc_o;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  can_irq_guard #(.NMBX(NMBX), .NBANK(NBANK)) u0 (.*);

  // {addr, be, init, empty[2:0], cfg[3:0], mbx[2:0], bank[3:0]}; filter init off, banks 0 and 2 active
  localparam int NV = 12;
  localparam logic [30:0] TBL [NV] = '{
    {12'h018, 4'hF, 1'b1, 3'b000, 4'b0001, 3'b000, 4'b0000},  // R7 init mode
    {12'h018, 4'hF, 1'b0, 3'b000, 4'b0000, 3'b000, 4'b0000},  // R7 running
    {12'h018, 4'h7, 1'b1, 3'b000, 4'b0000, 3'b000, 4'b0000},  // R2 partial
    {12'h020, 4'hF, 1'b1, 3'b111, 4'b0000, 3'b000, 4'b0000},  // R9 no filter init
    {12'h044, 4'hF, 1'b0, 3'b001, 4'b0000, 3'b001, 4'b0000},  // R8 mbx0 empty
    {12'h058, 4'hF, 1'b0, 3'b101, 4'b0000, 3'b000, 4'b0000},  // R8 mbx1 busy
    {12'h06C, 4'hF, 1'b0, 3'b100, 4'b0000, 3'b100, 4'b0000},  // R8 mbx2 last word
    {12'h100, 4'hF, 1'b0, 3'b000, 4'b0000, 3'b000, 4'b0000},  // R10 bank0 active
    {12'h10C, 4'hF, 1'b0, 3'b000, 4'b0000, 3'b000, 4'b0010},  // R10 bank1 idle
    {12'h11C, 4'hF, 1'b0, 3'b000, 4'b0000, 3'b000, 4'b1000},  // R10 bank3 idle
    {12'h114, 4'hF, 1'b0, 3'b000, 4'b0000, 3'b000, 4'b0000},  // R10 bank2 active
    {12'h10E, 4'hF, 1'b0, 3'b111, 4'b0000, 3'b000, 4'b0000}   // R2 misaligned
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a; bus_be = be;
    #1 d = bus_rdata;
  endtask

  // drive a write for part of a cycle only, sample the combinational strobes
  task automatic probe(input logic [11:0] a, input logic [3:0] be, input logic init,
                       input logic [2:0] empty, output logic [10:0] strb);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = 32'hFFFF_FFFF;
    init_mode_i = init; mbx_empty_i = empty; bus_wr = 1'b1;
    #1 strb = {cfg_wacc_o, mbx_wacc_o, fbank_wacc_o};
    bus_wr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [10:0] s;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, 4'hF, rv); check("R1 ctrl", rv, 32'h0001_0002);
    rd(12'h01C, 4'hF, rv); check("R1 fctl", rv, 32'h1);
    rd(12'h014, 4'hF, rv); check("R1 ien", rv, 32'h0);
    rd(12'h004, 4'hF, rv); check("R1 txf", rv, 32'h0);
    rd(12'h010, 4'hF, rv); check("R1 est", rv, 32'h0);
    check("R1 irqs", {28'd0, irq_tx_o, irq_rx0_o, irq_rx1_o, irq_es_o}, 32'h0);

    wr(12'h014, 32'hFFF, 4'hF);
    wr(12'h01C, 32'h0, 4'hF);
    wr(12'h02C, 32'h5, 4'hF);
    // R2 partial write ignored, partial read zero
    wr(12'h014, 32'h0, 4'h3);
    rd(12'h014, 4'hF, rv); check("R2 ien kept", rv, 32'hFFF);
    rd(12'h000, 4'h3, rv); check("R2 partial read", rv, 32'h0);

    for (int i = 0; i < NV; i++) begin
      probe(TBL[i][30:19], TBL[i][18:15], TBL[i][14], TBL[i][13:11], s);
      check($sformatf("R7/R8/R9/R10/R2 vec%0d", i), 32'(s), 32'(TBL[i][10:0]));
    end

    // R9 and R10 with filter init set
    wr(12'h01C, 32'h1, 4'hF);
    probe(12'h020, 4'hF, 1'b0, 3'b000, s); check("R9 fmode", 32'(s), 32'h100);
    probe(12'h024, 4'hF, 1'b0, 3'b000, s); check("R9 fscale", 32'(s), 32'h200);
    probe(12'h028, 4'hF, 1'b0, 3'b000, s); check("R9 fassign", 32'(s), 32'h400);
    probe(12'h100, 4'hF, 1'b0, 3'b000, s); check("R10 bank0 finit", 32'(s), 32'h001);
    probe(12'h070, 4'hF, 1'b0, 3'b111, s); check("R8 past last mbx", 32'(s), 32'h000);
    wr(12'h01C, 32'h0, 4'hF);

    // R3 sticky transmit flag and write-one clear
    @(negedge clk) tx_done_i = 3'b010;
    rd(12'h004, 4'hF, rv); tx_done_i = '0;
    check("R3 txf set", rv, 32'h2); check("R3 irq_tx", 32'(irq_tx_o), 32'h1);
    wr(12'h004, 32'h2, 4'hF);
    rd(12'h004, 4'hF, rv); check("R3 txf cleared", rv, 32'h0);
    check("R3 irq_tx low", 32'(irq_tx_o), 32'h0);

    // R6 set and clear together
    @(negedge clk);
    tx_done_i = 3'b001; bus_addr = 12'h004; bus_wdata = 32'h1; bus_be = 4'hF; bus_wr = 1'b1;
    @(negedge clk); tx_done_i = '0; bus_wr = 1'b0;
    rd(12'h004, 4'hF, rv); check("R6 set wins", rv, 32'h1);
    wr(12'h004, 32'h7, 4'hF);

    // R11 disabled event
    wr(12'h014, 32'hFFE, 4'hF);
    @(negedge clk) tx_done_i = 3'b001;
    rd(12'h004, 4'hF, rv); tx_done_i = '0;
    check("R11 flag set", rv, 32'h1); check("R11 irq_tx masked", 32'(irq_tx_o), 32'h0);
    @(negedge clk) tx_done_i = 3'b100;
    @(negedge clk) tx_done_i = '0;
    #1 check("R11 enabled mbx2", 32'(irq_tx_o), 32'h1);
    wr(12'h004, 32'h7, 4'hF);
    wr(12'h014, 32'hFFF, 4'hF);

    // R4 receive FIFO lines
    @(negedge clk) rx0_cnt_i = 2'd2;
    #1 check("R4 rx0 pending", {30'd0, irq_rx0_o, irq_rx1_o}, 32'h2);
    @(negedge clk) rx0_cnt_i = 2'd0;
    #1 check("R4 rx0 idle", 32'(irq_rx0_o), 32'h0);
    @(negedge clk) rx1_full_i = 1'b1;
    rd(12'h00C, 4'hF, rv); rx1_full_i = 1'b0;
    check("R4 rx1 full", rv, 32'h4); check("R4 irq_rx1", 32'(irq_rx1_o), 32'h1);
    @(negedge clk) rx0_ovr_i = 1'b1;
    rd(12'h008, 4'hF, rv); rx0_ovr_i = 1'b0;
    check("R4 rx0 ovr", rv, 32'h8); check("R4 irq_rx0 ovr", 32'(irq_rx0_o), 32'h1);
    wr(12'h00C, 32'h4, 4'hF);
    wr(12'h008, 32'h8, 4'hF);
    #1 check("R4 rx cleared", {30'd0, irq_rx0_o, irq_rx1_o}, 32'h0);
    wr(12'h014, 32'hFF7, 4'hF);
    @(negedge clk) rx0_cnt_i = 2'd1;
    rd(12'h008, 4'hF, rv);
    check("R11 rx0 count", rv, 32'h1); check("R11 rx0 pend masked", 32'(irq_rx0_o), 32'h0);
    rx0_cnt_i = 2'd0;
    wr(12'h014, 32'hFFF, 4'hF);

    // R5 error, sleep entry, wakeup
    @(negedge clk) err_i = 1'b1;
    #1 check("R5 err irq", 32'(irq_es_o), 32'h1);
    @(negedge clk) err_i = 1'b0;
    #1 check("R5 err gone", 32'(irq_es_o), 32'h0);
    @(negedge clk) sleep_i = 1'b0;
    @(negedge clk) sleep_i = 1'b1;
    rd(12'h010, 4'hF, rv); check("R5 sleep entry", rv, 32'h4);
    check("R5 sleep irq", 32'(irq_es_o), 32'h1);
    @(negedge clk) sof_i = 1'b1;
    rd(12'h010, 4'hF, rv); sof_i = 1'b0;
    check("R5 wakeup", rv, 32'h6);
    wr(12'h010, 32'h6, 4'hF);
    @(negedge clk) sleep_i = 1'b0;
    @(negedge clk) sof_i = 1'b1;
    rd(12'h010, 4'hF, rv); sof_i = 1'b0;
    check("R5 sof awake ignored", rv, 32'h0);
    check("R5 es irq low", 32'(irq_es_o), 32'h0);

    summary();
  end

endmodule